// File: doc/BRIEF.md
# Interrupt Pin Service and End-of-Interrupt Engine

This block watches a bank of interrupt input pins and turns their activity into delivery messages. Each pin has a routing entry, supplied on flat input buses by the table that holds it. The entry gives the vector, delivery mode, destination mode, destination, trigger type and mask. The block keeps one pending bit per pin and a remote-in-service flag per level pin. It always offers the lowest-numbered eligible pin on a registered valid/ready message port.

Edge pins latch a request on the rising transition of their synchronized input, and only while they are unmasked. A level pin's pending bit follows its input. Once a level pin is delivered, it stays silent until an end-of-interrupt broadcast arrives with its vector. Input 0 is folded onto pin 2. For pins in external-interrupt delivery mode, the vector comes from a legacy controller's acknowledge port and not from the entry. The remote flags are brought out so the table can show them.

Top module: `irq_pin_service`

## Requirements
- R1: After reset, `msg_valid`, `legacy_ack` and every bit of `remote_flags` are 0.
- R2: Input 0 never requests on its own pin. A rising edge on input 0 is treated as a request on pin 2, and no message ever names pin 0.
- R3: An edge pin (`cfg_level` bit 0) becomes pending on a rising transition of its synchronized input only while its `cfg_mask` bit is 0. A transition seen while masked is lost, even if the pin is unmasked later.
- R4: The pending bit of a level pin (`cfg_level` bit 1) follows its input. The pin is delivered only while its remote flag is 0. The delivery sets that flag, and while the flag is set the pin stays silent even though its input remains high.
- R5: When several pins are eligible at once, they are delivered in ascending pin order.
- R6: A message carries the entry's vector, delivery mode, destination mode, destination and trigger type, plus the pin number. Each rising edge on an edge pin yields exactly one message, however long the input stays high.
- R7: When the delivery mode is 3'b111, the message vector is `legacy_vec` as sampled when the message is loaded. `legacy_ack` pulses for one cycle in the first cycle the message is valid.
- R8: An end-of-interrupt clears the remote flag of every pin whose flag is set and whose vector equals `eoi_vec`. Flags with another vector are unchanged. A cleared pin that is still pending and unmasked is delivered again.
- R9: While `msg_valid` is 1 and `msg_ready` is 0, the message holds valid and every field stays stable. The next message is loaded only at acceptance.
- R10: Entry fields are evaluated continuously. A pending level pin that is unmasked is delivered without any new input activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | NUM_PINS | Asynchronous interrupt input levels |
| cfg_vec | input | NUM_PINS*VEC_W | Per-pin vector, pin p at bits p*VEC_W upward |
| cfg_dm | input | NUM_PINS*3 | Per-pin delivery mode, 3'b111 = external interrupt |
| cfg_dstm | input | NUM_PINS | Per-pin destination mode |
| cfg_dest | input | NUM_PINS*DEST_W | Per-pin destination |
| cfg_level | input | NUM_PINS | Trigger type: 1 level, 0 edge |
| cfg_mask | input | NUM_PINS | 1 masks the pin |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_vec | input | VEC_W | Vector carried by the end-of-interrupt |
| legacy_vec | input | VEC_W | Vector from the legacy controller acknowledge port |
| legacy_ack | output | 1 | Acknowledge pulse to the legacy controller |
| msg_valid | output | 1 | Message valid |
| msg_ready | input | 1 | Message accepted when high with valid |
| msg_vec | output | VEC_W | Message vector |
| msg_dm | output | 3 | Message delivery mode |
| msg_dstm | output | 1 | Message destination mode |
| msg_dest | output | DEST_W | Message destination |
| msg_level | output | 1 | Message trigger type |
| msg_pin | output | PIN_W | Pin that produced the message |
| remote_flags | output | NUM_PINS | Remote-in-service flag per pin |

## Verification
Short edge pulses and edge inputs held high for many cycles show whether one transition gives one message. Two pins rising in the same cycle behind a stalled consumer show both the ascending order and that a held message stays stable. A level input held high across end-of-interrupts with a wrong vector and then the right one tells gating apart from redelivery. Two level pins sharing a vector show that one broadcast clears both. Masked edge pulses followed by unmasking, and a masked level pin that is then unmasked, separate a lost edge from a request that is still pending.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int DM_W = 3;
  localparam logic [DM_W-1:0] DM_EXTERNAL = 3'b111;
  typedef enum logic { TRIG_EDGE = 1'b0, TRIG_LEVEL = 1'b1 } trig_e;
endpackage

// File: rtl/irq_in_sync.sv
module irq_in_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= d;
  end

  for (genvar k = 1; k < STAGES; k++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[k] <= '0;
      else     stg[k] <= stg[k-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/irq_pending.sv
module irq_pending #(
  parameter int NUM_PINS = 8,
  parameter int FOLD_SRC = 0,
  parameter int FOLD_DST = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] lvl,
  input  logic [NUM_PINS-1:0] cfg_level,
  input  logic [NUM_PINS-1:0] cfg_mask,
  input  logic [NUM_PINS-1:0] consume,
  output logic [NUM_PINS-1:0] pending
);
  logic [NUM_PINS-1:0] eff;
  logic [NUM_PINS-1:0] prev_q;
  logic [NUM_PINS-1:0] rise;
  logic [NUM_PINS-1:0] pend_q;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_fold
    if (i == FOLD_SRC) begin : g_src
      assign eff[i] = 1'b0;
    end else if (i == FOLD_DST) begin : g_dst
      assign eff[i] = lvl[i] | lvl[FOLD_SRC];
    end else begin : g_plain
      assign eff[i] = lvl[i];
    end
  end

  assign rise = eff & ~prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      pend_q <= '0;
    end else begin
      prev_q <= eff;
      for (int i = 0; i < NUM_PINS; i++) begin
        if (cfg_level[i]) pend_q[i] <= eff[i];
        else pend_q[i] <= (pend_q[i] & ~consume[i]) | (rise[i] & ~cfg_mask[i]);
      end
    end
  end

  assign pending = pend_q;
endmodule

// File: rtl/irq_remote.sv
module irq_remote #(
  parameter int NUM_PINS = 8,
  parameter int VEC_W    = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_PINS*VEC_W-1:0] cfg_vec,
  input  logic                      eoi_valid,
  input  logic [VEC_W-1:0]          eoi_vec,
  input  logic [NUM_PINS-1:0]       arm,
  output logic [NUM_PINS-1:0]       flags
);
  logic [NUM_PINS-1:0] hit;
  logic [NUM_PINS-1:0] flag_q;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_hit
    assign hit[i] = eoi_valid && flag_q[i] && (cfg_vec[i*VEC_W +: VEC_W] == eoi_vec);
  end

  always_ff @(posedge clk) begin
    if (rst) flag_q <= '0;
    else     flag_q <= (flag_q & ~hit) | arm;
  end

  assign flags = flag_q;
endmodule

// File: rtl/irq_deliver.sv
module irq_deliver
  import irq_route_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int VEC_W    = 8,
  parameter int DEST_W   = 8,
  localparam int PIN_W   = $clog2(NUM_PINS)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_PINS-1:0]        pending,
  input  logic [NUM_PINS-1:0]        flags,
  input  logic [NUM_PINS*VEC_W-1:0]  cfg_vec,
  input  logic [NUM_PINS*DM_W-1:0]   cfg_dm,
  input  logic [NUM_PINS-1:0]        cfg_dstm,
  input  logic [NUM_PINS*DEST_W-1:0] cfg_dest,
  input  logic [NUM_PINS-1:0]        cfg_level,
  input  logic [NUM_PINS-1:0]        cfg_mask,
  input  logic [VEC_W-1:0]           legacy_vec,
  input  logic                       ready,
  output logic                       valid,
  output logic                       ack,
  output logic [VEC_W-1:0]           m_vec,
  output logic [DM_W-1:0]            m_dm,
  output logic                       m_dstm,
  output logic [DEST_W-1:0]          m_dest,
  output logic                       m_level,
  output logic [PIN_W-1:0]           m_pin,
  output logic [NUM_PINS-1:0]        consume,
  output logic [NUM_PINS-1:0]        arm
);
  logic [NUM_PINS-1:0] elig;
  logic [PIN_W-1:0]    sel;
  logic                any;
  logic                load;
  logic [DM_W-1:0]     sel_dm;

  assign elig = pending & ~cfg_mask & (~cfg_level | ~flags);

  always_comb begin
    sel = '0;
    any = 1'b0;
    for (int i = NUM_PINS-1; i >= 0; i--) begin
      if (elig[i]) begin
        sel = PIN_W'(i);
        any = 1'b1;
      end
    end
  end

  assign load   = any && (!valid || ready);
  assign sel_dm = cfg_dm[int'(sel)*DM_W +: DM_W];

  always_comb begin
    consume = '0;
    arm     = '0;
    if (load) begin
      if (cfg_level[sel] == TRIG_LEVEL) arm[sel]     = 1'b1;
      else                               consume[sel] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid   <= 1'b0;
      ack     <= 1'b0;
      m_vec   <= '0;
      m_dm    <= '0;
      m_dstm  <= 1'b0;
      m_dest  <= '0;
      m_level <= 1'b0;
      m_pin   <= '0;
    end else begin
      ack <= load && (sel_dm == DM_EXTERNAL);
      if (load) begin
        valid   <= 1'b1;
        m_vec   <= (sel_dm == DM_EXTERNAL) ? legacy_vec : cfg_vec[int'(sel)*VEC_W +: VEC_W];
        m_dm    <= sel_dm;
        m_dstm  <= cfg_dstm[sel];
        m_dest  <= cfg_dest[int'(sel)*DEST_W +: DEST_W];
        m_level <= cfg_level[sel];
        m_pin   <= sel;
      end else if (ready) begin
        valid <= 1'b0;
      end
    end
  end

  a_r9_hold_stable: assert property (@(posedge clk) disable iff (rst)
    (valid && !ready) |=> (valid && $stable(m_vec) && $stable(m_pin) && $stable(m_dest)
                           && $stable(m_dm) && $stable(m_level) && $stable(m_dstm)));

  a_r7_ack_extint: assert property (@(posedge clk) disable iff (rst)
    ack |-> (valid && m_dm == DM_EXTERNAL));
endmodule

// File: rtl/irq_pin_service.sv
module irq_pin_service
  import irq_route_pkg::*;
#(
  parameter int NUM_PINS    = 8,
  parameter int VEC_W       = 8,
  parameter int DEST_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int FOLD_SRC    = 0,
  parameter int FOLD_DST    = 2,
  localparam int PIN_W      = $clog2(NUM_PINS)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_PINS-1:0]        pin_in,
  input  logic [NUM_PINS*VEC_W-1:0]  cfg_vec,
  input  logic [NUM_PINS*DM_W-1:0]   cfg_dm,
  input  logic [NUM_PINS-1:0]        cfg_dstm,
  input  logic [NUM_PINS*DEST_W-1:0] cfg_dest,
  input  logic [NUM_PINS-1:0]        cfg_level,
  input  logic [NUM_PINS-1:0]        cfg_mask,
  input  logic                       eoi_valid,
  input  logic [VEC_W-1:0]           eoi_vec,
  input  logic [VEC_W-1:0]           legacy_vec,
  output logic                       legacy_ack,
  output logic                       msg_valid,
  input  logic                       msg_ready,
  output logic [VEC_W-1:0]           msg_vec,
  output logic [DM_W-1:0]            msg_dm,
  output logic                       msg_dstm,
  output logic [DEST_W-1:0]          msg_dest,
  output logic                       msg_level,
  output logic [PIN_W-1:0]           msg_pin,
  output logic [NUM_PINS-1:0]        remote_flags
);
  logic [NUM_PINS-1:0] lvl_s;
  logic [NUM_PINS-1:0] pending;
  logic [NUM_PINS-1:0] consume;
  logic [NUM_PINS-1:0] arm;

  irq_in_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(pin_in), .q(lvl_s)
  );

  irq_pending #(.NUM_PINS(NUM_PINS), .FOLD_SRC(FOLD_SRC), .FOLD_DST(FOLD_DST)) u_pend (
    .clk(clk), .rst(rst), .lvl(lvl_s), .cfg_level(cfg_level), .cfg_mask(cfg_mask),
    .consume(consume), .pending(pending)
  );

  irq_remote #(.NUM_PINS(NUM_PINS), .VEC_W(VEC_W)) u_remote (
    .clk(clk), .rst(rst), .cfg_vec(cfg_vec), .eoi_valid(eoi_valid), .eoi_vec(eoi_vec),
    .arm(arm), .flags(remote_flags)
  );

  irq_deliver #(.NUM_PINS(NUM_PINS), .VEC_W(VEC_W), .DEST_W(DEST_W)) u_dlv (
    .clk(clk), .rst(rst), .pending(pending), .flags(remote_flags),
    .cfg_vec(cfg_vec), .cfg_dm(cfg_dm), .cfg_dstm(cfg_dstm), .cfg_dest(cfg_dest),
    .cfg_level(cfg_level), .cfg_mask(cfg_mask), .legacy_vec(legacy_vec),
    .ready(msg_ready), .valid(msg_valid), .ack(legacy_ack),
    .m_vec(msg_vec), .m_dm(msg_dm), .m_dstm(msg_dstm), .m_dest(msg_dest),
    .m_level(msg_level), .m_pin(msg_pin), .consume(consume), .arm(arm)
  );

  a_r2_fold_pin_silent: assert property (@(posedge clk) disable iff (rst)
    msg_valid |-> (msg_pin != PIN_W'(FOLD_SRC)));

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_chk
    a_r4_flag_rise_matches_msg: assert property (@(posedge clk) disable iff (rst)
      $rose(remote_flags[i]) |-> (msg_valid && msg_level && msg_pin == PIN_W'(i)));
  end
endmodule

// File: tb/test_irq_pin_service.sv
module test_irq_pin_service;
  localparam int NP = 8;
  localparam int VW = 8;
  localparam int DW = 8;

  typedef struct packed {
    logic [7:0] vec;
    logic [2:0] dm;
    logic       dstm;
    logic [7:0] dest;
    logic       lvl;
    logic [2:0] pin;
  } msg_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NP-1:0]    pin_in = '0;
  logic [NP*VW-1:0] cfg_vec = '0;
  logic [NP*3-1:0]  cfg_dm = '0;
  logic [NP-1:0]    cfg_dstm = '0;
  logic [NP*DW-1:0] cfg_dest = '0;
  logic [NP-1:0]    cfg_level = '0;
  logic [NP-1:0]    cfg_mask = '1;
  logic             eoi_valid = 1'b0;
  logic [VW-1:0]    eoi_vec = '0;
  logic [VW-1:0]    legacy_vec = '0;
  logic             legacy_ack;
  logic             msg_valid;
  logic             msg_ready = 1'b1;
  logic [VW-1:0]    msg_vec;
  logic [2:0]       msg_dm;
  logic             msg_dstm;
  logic [DW-1:0]    msg_dest;
  logic             msg_level;
  logic [2:0]       msg_pin;
  logic [NP-1:0]    remote_flags;

  int n_vec = 0;
  int n_bad = 0;
  int n_deliv = 0;
  int n_ack = 0;
  bit done = 1'b0;
  msg_t q[$];

  always #2.5 clk = ~clk;

  irq_pin_service #(.NUM_PINS(NP), .VEC_W(VW), .DEST_W(DW)) i_irq_pin_service (
    .clk(clk), .rst(rst), .pin_in(pin_in), .cfg_vec(cfg_vec), .cfg_dm(cfg_dm),
    .cfg_dstm(cfg_dstm), .cfg_dest(cfg_dest), .cfg_level(cfg_level), .cfg_mask(cfg_mask),
    .eoi_valid(eoi_valid), .eoi_vec(eoi_vec), .legacy_vec(legacy_vec),
    .legacy_ack(legacy_ack), .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_vec(msg_vec), .msg_dm(msg_dm), .msg_dstm(msg_dstm), .msg_dest(msg_dest),
    .msg_level(msg_level), .msg_pin(msg_pin), .remote_flags(remote_flags)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic set_pin(input int p, input logic [7:0] v, input logic [2:0] dm,
                         input logic dstm, input logic [7:0] dest, input logic lvl,
                         input logic msk);
    cfg_vec[p*VW +: VW]  = v;
    cfg_dm[p*3 +: 3]     = dm;
    cfg_dstm[p]          = dstm;
    cfg_dest[p*DW +: DW] = dest;
    cfg_level[p]         = lvl;
    cfg_mask[p]          = msk;
  endtask

  task automatic expect_pin(input int p);
    msg_t m;
    m.dm   = cfg_dm[p*3 +: 3];
    m.vec  = (m.dm == 3'b111) ? legacy_vec : cfg_vec[p*VW +: VW];
    m.dstm = cfg_dstm[p];
    m.dest = cfg_dest[p*DW +: DW];
    m.lvl  = cfg_level[p];
    m.pin  = 3'(p);
    q.push_back(m);
  endtask

  task automatic drain(input string tag);
    tick(14);
    chk(q.size() == 0, tag, q.size(), 0);
  endtask

  task automatic eoi(input logic [7:0] v);
    eoi_valid = 1'b1;
    eoi_vec   = v;
    tick(1);
    eoi_valid = 1'b0;
  endtask

  // Scoreboard monitor: compare each accepted message against the queue front.
  always @(negedge clk) begin
    if (!rst && legacy_ack) n_ack++;
    if (!rst && msg_valid && msg_ready) begin
      msg_t got;
      got = '{vec: msg_vec, dm: msg_dm, dstm: msg_dstm, dest: msg_dest,
              lvl: msg_level, pin: msg_pin};
      n_deliv++;
      if (q.size() == 0) begin
        chk(1'b0, "R6 unexpected message", longint'(got), 0);
      end else begin
        msg_t e;
        e = q.pop_front();
        chk(got == e, "R6 message content/order", longint'(got), longint'(e));
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog expired", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin : driver
    msg_t snap;
    int d0;
    int a0;
    for (int p = 0; p < NP; p++) set_pin(p, 8'h10 + 8'(p), 3'd0, 1'b0, 8'(p), 1'b0, 1'b1);
    tick(4);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(msg_valid == 1'b0, "R1 msg_valid after reset", msg_valid, 0);
    chk(remote_flags == '0, "R1 remote_flags after reset", remote_flags, 0);
    chk(legacy_ack == 1'b0, "R1 legacy_ack after reset", legacy_ack, 0);
    tick(1);

    // R6: edge pin held high yields one message with all entry fields
    set_pin(3, 8'h33, 3'b001, 1'b1, 8'h83, 1'b0, 1'b0);
    expect_pin(3);
    pin_in[3] = 1'b1;
    tick(12);
    pin_in[3] = 1'b0;
    drain("R6 single message per edge");

    // R5 + R9: two simultaneous edges behind a stalled consumer
    set_pin(1, 8'h41, 3'b000, 1'b0, 8'h01, 1'b0, 1'b0);
    set_pin(5, 8'h45, 3'b010, 1'b0, 8'h05, 1'b0, 1'b0);
    msg_ready = 1'b0;
    expect_pin(1);
    expect_pin(5);
    pin_in[1] = 1'b1;
    pin_in[5] = 1'b1;
    tick(8);
    @(negedge clk);
    snap = '{vec: msg_vec, dm: msg_dm, dstm: msg_dstm, dest: msg_dest, lvl: msg_level, pin: msg_pin};
    chk(msg_valid && msg_pin == 3'd1, "R5 lowest pin offered first", msg_pin, 1);
    tick(3);
    @(negedge clk);
    chk(msg_valid, "R9 valid held while stalled", msg_valid, 1);
    chk(snap == '{vec: msg_vec, dm: msg_dm, dstm: msg_dstm, dest: msg_dest, lvl: msg_level, pin: msg_pin},
        "R9 fields stable while stalled", msg_vec, snap.vec);
    tick(1);
    msg_ready = 1'b1;
    pin_in[1] = 1'b0;
    pin_in[5] = 1'b0;
    drain("R5 ascending delivery");

    // R3: masked edge is lost even after unmasking
    d0 = n_deliv;
    pin_in[4] = 1'b1;
    tick(3);
    pin_in[4] = 1'b0;
    tick(8);
    set_pin(4, 8'h44, 3'd0, 1'b0, 8'h04, 1'b0, 1'b0);
    tick(14);
    chk(n_deliv == d0, "R3 masked edge dropped", n_deliv - d0, 0);
    set_pin(4, 8'h44, 3'd0, 1'b0, 8'h04, 1'b0, 1'b1);

    // R2: input 0 folds onto pin 2; pin 0 entry unmasked but silent
    set_pin(0, 8'h02, 3'd0, 1'b0, 8'h00, 1'b0, 1'b0);
    set_pin(2, 8'h22, 3'd0, 1'b0, 8'h02, 1'b0, 1'b0);
    expect_pin(2);
    pin_in[0] = 1'b1;
    tick(3);
    pin_in[0] = 1'b0;
    drain("R2 input 0 delivered as pin 2");
    set_pin(0, 8'h02, 3'd0, 1'b0, 8'h00, 1'b0, 1'b1);

    // R4 / R8: level pin gating and end-of-interrupt
    set_pin(6, 8'h66, 3'd0, 1'b0, 8'h06, 1'b1, 1'b0);
    expect_pin(6);
    pin_in[6] = 1'b1;
    tick(10);
    chk(remote_flags[6] == 1'b1, "R4 flag set by level delivery", remote_flags[6], 1);
    drain("R4 no repeat while flag set");
    eoi(8'h65);
    tick(10);
    chk(remote_flags[6] == 1'b1, "R8 wrong vector leaves flag", remote_flags[6], 1);
    chk(q.size() == 0, "R8 wrong vector no redelivery", q.size(), 0);
    expect_pin(6);
    eoi(8'h66);
    tick(10);
    chk(remote_flags[6] == 1'b1, "R8 redelivery re-arms flag", remote_flags[6], 1);
    drain("R8 redelivery after matching broadcast");
    pin_in[6] = 1'b0;
    tick(6);
    eoi(8'h66);
    tick(2);
    chk(remote_flags[6] == 1'b0, "R8 flag cleared", remote_flags[6], 0);
    drain("R4 no delivery with input low");

    // R10: masked pending level pin delivered on unmask
    set_pin(7, 8'h66, 3'b100, 1'b1, 8'hF7, 1'b1, 1'b1);
    d0 = n_deliv;
    pin_in[7] = 1'b1;
    tick(12);
    chk(n_deliv == d0, "R10 masked level held back", n_deliv - d0, 0);
    expect_pin(7);
    set_pin(7, 8'h66, 3'b100, 1'b1, 8'hF7, 1'b1, 1'b0);
    tick(6);
    chk(remote_flags[7] == 1'b1, "R10 unmask delivers pending level", remote_flags[7], 1);
    expect_pin(6);
    pin_in[6] = 1'b1;
    drain("R10 deliveries");
    pin_in[6] = 1'b0;
    pin_in[7] = 1'b0;
    tick(6);
    eoi(8'h66);
    tick(2);
    chk(remote_flags[7:6] == 2'b00, "R8 one broadcast clears both pins", remote_flags[7:6], 0);

    // R7: external-interrupt mode takes legacy vector and pulses acknowledge
    legacy_vec = 8'hA5;
    set_pin(1, 8'h11, 3'b111, 1'b0, 8'h31, 1'b0, 1'b0);
    a0 = n_ack;
    expect_pin(1);
    pin_in[1] = 1'b1;
    tick(3);
    pin_in[1] = 1'b0;
    drain("R7 legacy vector used");
    chk(n_ack == a0 + 1, "R7 one acknowledge pulse", n_ack - a0, 1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule